// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns a column offset and a page number into the ordered series of byte-wide address cycles that a NAND flash device takes after a command byte. A request is launched with a one-cycle `start` strobe. The strobe is taken only while the block is idle. It carries the column value, the page value and a page mask taken from the device's page count. Two flags say whether the column part and the page part are present. The block then offers one address byte at a time on a valid/ready pair. When the final byte is taken, it signals completion with a one-cycle `done` pulse.

The count of column cycles follows the page geometry. That geometry is decoded from three packed boot-configuration pins: a page-size bit and a two-bit location field. A separate pin selects the bus width. The decoded page size, spare size and bus width also appear as outputs, so a neighbouring command/data engine can use the same decode.

Page bytes go out least significant first. After each page byte, both the page value and the mask shift down by eight bits. Page cycles stop once the shifted mask reaches zero, and at least one page cycle is always sent.

Top module: `nand_addr_seq`

## Requirements
- R1: During and right after reset, `cyc_valid`, `done` and `busy` are all 0.
- R2: With `has_col` = 1, the first address byte offered is column bits 7:0.
- R3: The second column cycle depends on the page geometry latched at `start`. For a 2048-byte page it carries column bits 11:8 masked with 0x0F. For a 4096-byte page it carries column bits 12:8 masked with 0x1F. A 512-byte page has no second column cycle.
- R4: With `has_page` = 1, page bytes follow the column bytes, least significant byte first. After each page byte the page value and the mask both shift right by 8. The cycles end when the shifted mask is zero, with a minimum of one page cycle.
- R5: A part whose flag is 0 emits no cycles. With both flags 0, `done` pulses in the cycle after `start` and no byte is offered.
- R6: While `cyc_valid` = 1 and `cyc_ready` = 0, both `cyc_valid` and `cyc_byte` hold their values.
- R7: `done` is high for exactly one cycle, the cycle right after the final byte is accepted. During that cycle `cyc_valid` and `busy` are 0.
- R8: Geometry code {`cfg_page_bit`, `cfg_loc[1:0]`} decodes as follows: codes 0–1 give a 512-byte page with a 16-byte spare; codes 2–3 give 4096/128; codes 4–5 give 2048/64; codes 6–7 give 4096/218.
- R9: `geo_wide` is 1 (16-bit bus) when `cfg_wide` = 1, and 0 (8-bit bus) otherwise.
- R10: A `start` that arrives while a sequence is in progress is ignored, and the sequence already running is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a sequence (taken only when idle) |
| has_col | input | 1 | Column part present |
| has_page | input | 1 | Page part present |
| col | input | COL_W | Column offset |
| page | input | PAGE_W | Page number |
| page_mask | input | PAGE_W | Mask derived from the device page count |
| cfg_page_bit | input | 1 | Page-size configuration bit |
| cfg_loc | input | 2 | Location configuration field |
| cfg_wide | input | 1 | Bus-width configuration bit |
| cyc_valid | output | 1 | Address byte offered |
| cyc_byte | output | 8 | Address byte |
| cyc_ready | input | 1 | Consumer accepts the byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| geo_page_bytes | output | 13 | Decoded page size in bytes |
| geo_spare_bytes | output | 8 | Decoded spare size in bytes |
| geo_wide | output | 1 | Decoded 16-bit bus flag |

## Verification
The first address byte is due one clock after `start` is taken. Each later byte is due one clock after the previous byte is accepted. `done` is due one clock after the final acceptance, or one clock after `start` when no part is present. The geometry outputs follow the pins with no register. The bench drives its inputs and samples at falling edges. Each test waits out the strobe edge before it reads the first byte, and it records the acceptance state at each falling edge so it can check that `done` arrives exactly one sample after the last accepted byte. The geometry outputs are read a short settling delay after the pins change.

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int COL_W  = 13,
  parameter int PAGE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              has_col,
  input  logic              has_page,
  input  logic [COL_W-1:0]  col,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] page_mask,
  input  logic              cfg_page_bit,
  input  logic [1:0]        cfg_loc,
  input  logic              cfg_wide,
  output logic              cyc_valid,
  output logic [7:0]        cyc_byte,
  input  logic              cyc_ready,
  output logic              busy,
  output logic              done,
  output logic [12:0]       geo_page_bytes,
  output logic [7:0]        geo_spare_bytes,
  output logic              geo_wide
);
  typedef enum logic [2:0] {S_IDLE, S_COL_LO, S_COL_HI, S_PAGE, S_FIN} st_t;

  st_t               st;
  logic [15:0]       col_r;
  logic [PAGE_W-1:0] page_r, mask_r;
  logic              big_r, huge_r, pg_r;

  wire is_big  = cfg_page_bit & ~cfg_loc[1];
  wire is_huge = cfg_loc[1];
  wire idle    = (st == S_IDLE);
  wire acc     = cyc_valid & cyc_ready;
  wire [PAGE_W-1:0] mask_nx = mask_r >> 8;

  assign geo_page_bytes  = is_huge ? 13'd4096 : (is_big ? 13'd2048 : 13'd512);
  assign geo_spare_bytes = is_huge ? (cfg_page_bit ? 8'd218 : 8'd128)
                                   : (is_big ? 8'd64 : 8'd16);
  assign geo_wide        = cfg_wide;

  assign cyc_valid = (st == S_COL_LO) || (st == S_COL_HI) || (st == S_PAGE);
  assign busy      = cyc_valid;
  assign done      = (st == S_FIN);

  always_comb begin
    case (st)
      S_COL_LO: cyc_byte = col_r[7:0];
      S_COL_HI: cyc_byte = huge_r ? {3'b000, col_r[12:8]} : {4'b0000, col_r[11:8]};
      S_PAGE:   cyc_byte = page_r[7:0];
      default:  cyc_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      col_r  <= '0;
      page_r <= '0;
      mask_r <= '0;
      big_r  <= 1'b0;
      huge_r <= 1'b0;
      pg_r   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          col_r  <= 16'(col);
          page_r <= page;
          mask_r <= page_mask;
          big_r  <= is_big;
          huge_r <= is_huge;
          pg_r   <= has_page;
          st     <= has_col ? S_COL_LO : (has_page ? S_PAGE : S_FIN);
        end
        S_COL_LO: if (acc)
          st <= (big_r || huge_r) ? S_COL_HI : (pg_r ? S_PAGE : S_FIN);
        S_COL_HI: if (acc)
          st <= pg_r ? S_PAGE : S_FIN;
        S_PAGE: if (acc) begin
          page_r <= page_r >> 8;
          mask_r <= mask_nx;
          if (mask_nx == '0) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_addr_seq_chk.sv
module nand_addr_seq_chk #(
  parameter int COL_W  = 13,
  parameter int PAGE_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             has_col,
  input logic             has_page,
  input logic [COL_W-1:0] col,
  input logic             cfg_page_bit,
  input logic [1:0]       cfg_loc,
  input logic             cyc_valid,
  input logic [7:0]       cyc_byte,
  input logic             cyc_ready,
  input logic             busy,
  input logic             done,
  input logic [12:0]      geo_page_bytes,
  input logic [7:0]       geo_spare_bytes
);
  wire idle = !busy && !done;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !cyc_valid && !done && !busy);

  a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle && has_col |=> cyc_valid && cyc_byte == $past(col[7:0]));

  a_r5_empty: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle && !has_col && !has_page |=> done && !cyc_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_byte));

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n) done |-> !cyc_valid && !busy);

  a_r8_half_k: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_page_bit && !cfg_loc[1] |-> geo_page_bytes == 13'd512 && geo_spare_bytes == 8'd16);

  a_r8_two_k: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_page_bit && !cfg_loc[1] |-> geo_page_bytes == 13'd2048 && geo_spare_bytes == 8'd64);
endmodule

bind nand_addr_seq nand_addr_seq_chk #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .has_col(has_col), .has_page(has_page),
  .col(col), .cfg_page_bit(cfg_page_bit), .cfg_loc(cfg_loc), .cyc_valid(cyc_valid),
  .cyc_byte(cyc_byte), .cyc_ready(cyc_ready), .busy(busy), .done(done),
  .geo_page_bytes(geo_page_bytes), .geo_spare_bytes(geo_spare_bytes)
);

// File: tb/tb_nand_addr_seq.sv
module tb_nand_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 13;
  localparam int PAGE_W = 24;

  logic clk = 0, rst_n = 0, start = 0, has_col = 0, has_page = 0;
  logic [COL_W-1:0] col = '0;
  logic [PAGE_W-1:0] page = '0, page_mask = '0;
  logic cfg_page_bit = 0, cfg_wide = 0, cyc_ready = 1;
  logic [1:0] cfg_loc = 0;
  logic cyc_valid, busy, done, geo_wide;
  logic [7:0] cyc_byte, geo_spare_bytes;
  logic [12:0] geo_page_bytes;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_addr_seq #(.COL_W(COL_W), .PAGE_W(PAGE_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .has_col(has_col), .has_page(has_page),
    .col(col), .page(page), .page_mask(page_mask), .cfg_page_bit(cfg_page_bit),
    .cfg_loc(cfg_loc), .cfg_wide(cfg_wide), .cyc_valid(cyc_valid), .cyc_byte(cyc_byte),
    .cyc_ready(cyc_ready), .busy(busy), .done(done), .geo_page_bytes(geo_page_bytes),
    .geo_spare_bytes(geo_spare_bytes), .geo_wide(geo_wide)
  );

  task automatic check(string req, bit ok, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run(string req, bit pb, bit [1:0] loc, bit hc, bit hp,
                     int c, int p, int m, int stall, bit poke);
    byte unsigned exp[$];
    byte unsigned got[$];
    bit fin = 0, prev_acc = 0, prev_stall = 0;
    byte unsigned held = 0;
    int pv = p, mv = m;
    if (hc) begin
      exp.push_back(c[7:0]);
      if (loc[1]) exp.push_back({3'b0, c[12:8]});
      else if (pb) exp.push_back({4'b0, c[11:8]});
    end
    if (hp) begin
      do begin
        exp.push_back(pv[7:0]);
        pv = pv >> 8; mv = mv >> 8;
      end while (mv != 0);
    end
    cfg_page_bit = pb; cfg_loc = loc; has_col = hc; has_page = hp;
    col = c[COL_W-1:0]; page = p[PAGE_W-1:0]; page_mask = m[PAGE_W-1:0];
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 80 && !fin; i++) begin
      cyc_ready = (stall != 0) ? ((i % 3) != 1) : 1'b1;
      if (poke && i == 1) begin
        start = 1; has_col = 1; has_page = 1; col = ~col; page = ~page;
      end else start = 0;
      if (prev_stall) check({req, " R6 hold"}, cyc_valid && cyc_byte == held, cyc_byte, held);
      if (done) begin
        fin = 1;
        check({req, " R7 timing"}, prev_acc || (exp.size() == 0 && i == 0), i, 0);
        check({req, " R7 quiet"}, !busy && !cyc_valid, {busy, cyc_valid}, 0);
      end else if (cyc_valid && cyc_ready) got.push_back(cyc_byte);
      prev_acc = cyc_valid && cyc_ready;
      prev_stall = cyc_valid && !cyc_ready;
      held = cyc_byte;
      @(negedge clk);
    end
    start = 0; cyc_ready = 1;
    check({req, " done seen"}, fin, fin, 1);
    check({req, " done single"}, !done, done, 0);
    check({req, " count"}, got.size() == exp.size(), got.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got.size(); k++)
      check({req, " byte"}, got[k] == exp[k], got[k], exp[k]);
  endtask

  task automatic t_reset();
    check("R1 reset", !cyc_valid && !done && !busy, {cyc_valid, done, busy}, 0);
  endtask

  task automatic t_geometry();
    int ep, es;
    for (int code = 0; code < 8; code++) begin
      {cfg_page_bit, cfg_loc} = code[2:0];
      case (code)
        0, 1: begin ep = 512;  es = 16;  end
        2, 3: begin ep = 4096; es = 128; end
        4, 5: begin ep = 2048; es = 64;  end
        default: begin ep = 4096; es = 218; end
      endcase
      #1;
      check("R8 page size", geo_page_bytes == ep[12:0], geo_page_bytes, ep);
      check("R8 spare size", geo_spare_bytes == es[7:0], geo_spare_bytes, es);
    end
    for (int w = 0; w < 2; w++) begin
      cfg_wide = w[0];
      #1;
      check("R9 width", geo_wide == w[0], geo_wide, w);
    end
    cfg_wide = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_geometry();
    run("R2 R3 R4 2k",       1, 2'b00, 1, 1, 'h1F7A, 'h012345, 'h01FFFF, 0, 0);
    run("R3 R4 4k",          0, 2'b10, 1, 1, 'h1F7A, 'hA5C3, 'hFF, 0, 0);
    run("R3 4k 218",         1, 2'b11, 1, 0, 'h1FFF, 0, 0, 0, 0);
    run("R3 512",            0, 2'b01, 1, 1, 'h1FF, 'h77, 'h3FF, 0, 0);
    run("R5 column only",    1, 2'b00, 1, 0, 'h0ABC, 'h1234, 'hFFFF, 0, 0);
    run("R4 R5 page min",    0, 2'b00, 0, 1, 0, 'h9ABCDE, 0, 0, 0);
    run("R5 none",           1, 2'b00, 0, 0, 'h123, 'h456, 'hFFF, 0, 0);
    run("R6 stall",          0, 2'b10, 1, 1, 'h1234, 'h345678, 'hFFFFFF, 1, 0);
    run("R10 busy start",    1, 2'b01, 1, 1, 'h0456, 'h0089AB, 'hFFFF, 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule